// File: doc/BRIEF.md
# Dual-Channel Programmable Timer with Match Interrupts

This peripheral holds two 16-bit counters, each paced by its own prescaler and governed by a small control field. The field starts or halts the counter, picks its direction and chooses how a run ends: at zero, at the value held in one of six shared compare registers, or never. Driver software loads a count while the channel is halted and then writes the control field to start it. The counter then advances once per prescaler period until its end condition, where the channel halts itself.

Only the first channel is compared against the compare registers. When it lands on the selected compare value it raises one pending bit in a six-bit event register. A companion enable register gates each pending bit onto a single level-sensitive interrupt line. Pending bits are cleared by writing ones to the event register's own address. The second channel is normally left free-running as a monotonic time base.

Access is through a plain 32-bit register port with a byte address, a select and a write strobe. Reads are combinational and have no side effects.

Top module: `mtmr_top`

## Requirements
- R1: Register map by byte address. Channel 0 has count at 0x00, prescale at 0x04 and control at 0x08. Channel 1 has count at 0x0C, prescale at 0x10 and control at 0x14. Compare register n (n = 0..5) is at 0x18 + 4n. The event register is at 0x30 and the enable register at 0x34. Count, prescale and compare registers keep the low 16 written bits, control keeps 5 bits, and event/enable keep 6 bits. Unused read bits return 0.
- R2: After reset, both counts, both prescalers, all compare registers, the event register and the enable register read 0. Both control registers read 0x10 (halted), and the interrupt line is low.
- R3: Control bit 4 = 1 halts the channel and 0 runs it. Bit 3 = 1 counts up and 0 counts down. Bits 2:0 select the end mode. A halted channel holds its count. A write to the count register loads it, and a following run write starts counting from that value.
- R4: With prescale value D, a running channel steps once every D+1 clocks. Its first step lands D+1 clock edges after the edge that captured the run write.
- R5: End mode 0 stops the channel at the step where the count becomes 0 by setting control bit 4. No event bit is raised. A load of 0xFFFF counting down takes exactly 65535 steps.
- R6: On channel 0, end mode n+1 (n = 0..5) stops the channel at the step where the count becomes equal to compare register n. That step sets control bit 4 and raises event bit n.
- R7: End mode 7 never stops and wraps modulo 2^16 in either direction. On channel 1, end modes 1..6 behave as mode 7 and never raise an event bit.
- R8: Writing the event register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R9: The interrupt line is high exactly when some event bit and the same enable bit are both 1. It stays high until that bit is cleared or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions watch the channel 0 end-of-match path on every cycle. A compare hit must raise exactly one event bit on the next edge and halt the channel. A halted channel must not move unless its count is written. Pending bits not written with ones must persist, and the line must be quiet right after reset. Prescaler pacing, exact step counts, wraparound, the channel 1 mode aliasing and the enable/clear sequence on the interrupt line are shown only by the bench's scenarios. These include the full 0xFFFF countdown and randomized compare runs with random direction, distance and prescale.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
    localparam int CTL_W = 5;

    typedef struct packed {
        logic       stop;
        logic       up;
        logic [2:0] mode;
    } ctl_t;

    localparam logic [2:0] MODE_ZERO    = 3'd0;
    localparam logic [2:0] MODE_FOREVER = 3'd7;
    localparam ctl_t       CTL_RESET    = '{stop: 1'b1, up: 1'b0, mode: MODE_ZERO};
endpackage

// File: rtl/mtmr_chan.sv
module mtmr_chan
    import mtmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter bit HAS_MATCH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt_i,
    input  logic             wr_div_i,
    input  logic             wr_ctl_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] term_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] div_o,
    output ctl_t             ctl_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] div;
        logic [CNT_W-1:0] pre;
        ctl_t             ctl;
    } chan_st_t;

    chan_st_t         st_d, st_q;
    logic             step;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        st_d  = st_q;
        hit_o = 1'b0;
        step  = !st_q.ctl.stop && (st_q.pre == st_q.div);
        nxt   = st_q.ctl.up ? st_q.cnt + 1'b1 : st_q.cnt - 1'b1;

        if (st_q.ctl.stop || step) st_d.pre = '0;
        else                       st_d.pre = st_q.pre + 1'b1;

        if (step) begin
            st_d.cnt = nxt;
            if (st_q.ctl.mode == MODE_ZERO) begin
                if (nxt == '0) st_d.ctl.stop = 1'b1;
            end else if (HAS_MATCH && st_q.ctl.mode != MODE_FOREVER) begin
                if (nxt == term_val_i) begin
                    st_d.ctl.stop = 1'b1;
                    hit_o         = 1'b1;
                end
            end
        end

        if (wr_cnt_i) st_d.cnt = wdata_i;
        if (wr_div_i) st_d.div = wdata_i;
        if (wr_ctl_i) begin
            st_d.ctl = ctl_t'(wdata_i[CTL_W-1:0]);
            st_d.pre = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.div <= '0;
            st_q.pre <= '0;
            st_q.ctl <= CTL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign div_o = st_q.div;
    assign ctl_o = st_q.ctl;
endmodule

// File: rtl/mtmr_irq.sv
module mtmr_irq #(
    parameter int N_EVT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] set_i,
    input  logic             wr_stat_i,
    input  logic             wr_mask_i,
    input  logic [N_EVT-1:0] wdata_i,
    output logic [N_EVT-1:0] stat_o,
    output logic [N_EVT-1:0] mask_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [N_EVT-1:0] stat;
        logic [N_EVT-1:0] mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stat_i) st_d.stat = st_q.stat & ~wdata_i;
        st_d.stat = st_d.stat | set_i;
        if (wr_mask_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.stat & st_q.mask);
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int N_CHAN  = 2,
    parameter int N_MATCH = 6,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int REG_B      = 4;
    localparam int CHAN_B     = 3 * REG_B;
    localparam int MATCH_BASE = N_CHAN * CHAN_B;
    localparam int STAT_ADDR  = MATCH_BASE + N_MATCH * REG_B;
    localparam int MASK_ADDR  = STAT_ADDR + REG_B;

    logic             wr_en;
    logic [CNT_W-1:0] cnt_w [N_CHAN];
    logic [CNT_W-1:0] div_w [N_CHAN];
    ctl_t             ctl_w [N_CHAN];
    logic             hit_w [N_CHAN];
    logic             wr_cnt_w [N_CHAN];
    logic             wr_ctl_w [N_CHAN];
    logic [CNT_W-1:0] match_d [N_MATCH];
    logic [CNT_W-1:0] match_q [N_MATCH];
    logic [CNT_W-1:0] term_val;
    logic [N_MATCH-1:0] set_vec, stat_w, mask_w;
    logic             unused_hi;

    assign wr_en     = bus_sel && bus_wr;
    assign unused_hi = &{1'b0, bus_wdata[DATA_W-1:CNT_W]};

    // compare value selected by channel 0's end mode
    always_comb begin
        term_val = '0;
        for (int n = 0; n < N_MATCH; n++)
            if (ctl_w[0].mode == 3'(n + 1)) term_val = match_q[n];
    end

    always_comb begin
        set_vec = '0;
        for (int n = 0; n < N_MATCH; n++)
            if (hit_w[0] && ctl_w[0].mode == 3'(n + 1)) set_vec[n] = 1'b1;
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(c * CHAN_B);
        localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(c * CHAN_B + REG_B);
        localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(c * CHAN_B + 2 * REG_B);
        logic wr_div;

        assign wr_cnt_w[c] = wr_en && bus_addr == A_CNT;
        assign wr_div      = wr_en && bus_addr == A_DIV;
        assign wr_ctl_w[c] = wr_en && bus_addr == A_CTL;

        mtmr_chan #(.CNT_W(CNT_W), .HAS_MATCH(c == 0)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_cnt_i  (wr_cnt_w[c]),
            .wr_div_i  (wr_div),
            .wr_ctl_i  (wr_ctl_w[c]),
            .wdata_i   (bus_wdata[CNT_W-1:0]),
            .term_val_i(term_val),
            .cnt_o     (cnt_w[c]),
            .div_o     (div_w[c]),
            .ctl_o     (ctl_w[c]),
            .hit_o     (hit_w[c])
        );
    end

    always_comb begin
        for (int n = 0; n < N_MATCH; n++) begin
            match_d[n] = match_q[n];
            if (wr_en && bus_addr == ADDR_W'(MATCH_BASE + n * REG_B))
                match_d[n] = bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < N_MATCH; n++) match_q[n] <= '0;
        end else begin
            for (int n = 0; n < N_MATCH; n++) match_q[n] <= match_d[n];
        end
    end

    mtmr_irq #(.N_EVT(N_MATCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .wr_stat_i(wr_en && bus_addr == ADDR_W'(STAT_ADDR)),
        .wr_mask_i(wr_en && bus_addr == ADDR_W'(MASK_ADDR)),
        .wdata_i  (bus_wdata[N_MATCH-1:0]),
        .stat_o   (stat_w),
        .mask_o   (mask_w),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < N_CHAN; c++) begin
            if (bus_addr == ADDR_W'(c * CHAN_B))
                bus_rdata = DATA_W'(cnt_w[c]);
            if (bus_addr == ADDR_W'(c * CHAN_B + REG_B))
                bus_rdata = DATA_W'(div_w[c]);
            if (bus_addr == ADDR_W'(c * CHAN_B + 2 * REG_B))
                bus_rdata = DATA_W'(ctl_w[c]);
        end
        for (int n = 0; n < N_MATCH; n++)
            if (bus_addr == ADDR_W'(MATCH_BASE + n * REG_B))
                bus_rdata = DATA_W'(match_q[n]);
        if (bus_addr == ADDR_W'(STAT_ADDR)) bus_rdata = DATA_W'(stat_w);
        if (bus_addr == ADDR_W'(MASK_ADDR)) bus_rdata = DATA_W'(mask_w);
    end
endmodule

// File: rtl/mtmr_chk.sv
module mtmr_chk #(
    parameter int CNT_W     = 16,
    parameter int N_MATCH   = 6,
    parameter int ADDR_W    = 8,
    parameter int STAT_ADDR = 48
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [N_MATCH-1:0] bus_wlow,
    input logic               irq,
    input logic [N_MATCH-1:0] status,
    input logic [N_MATCH-1:0] set_vec,
    input logic               stop0,
    input logic [CNT_W-1:0]   cnt0,
    input logic               wr_cnt0,
    input logic               wr_ctl0
);
    logic [N_MATCH-1:0] clr_bits;
    assign clr_bits = (bus_sel && bus_wr && bus_addr == ADDR_W'(STAT_ADDR)) ? bus_wlow : '0;

    // R6
    one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));

    // R6
    hit_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

    // R6
    hit_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0 && !wr_ctl0) |=> stop0);

    // R3
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop0 && !wr_cnt0) |=> $stable(cnt0));

    // R8
    keep_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~clr_bits) != '0) |=>
        ((status & $past(status & ~clr_bits)) == $past(status & ~clr_bits)));

    // R2
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);
endmodule

bind mtmr_top mtmr_chk #(
    .CNT_W(CNT_W), .N_MATCH(N_MATCH), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .bus_wlow(bus_wdata[N_MATCH-1:0]),
    .irq     (irq_o),
    .status  (stat_w),
    .set_vec (set_vec),
    .stop0   (ctl_w[0].stop),
    .cnt0    (cnt_w[0]),
    .wr_cnt0 (wr_cnt_w[0]),
    .wr_ctl0 (wr_ctl_w[0])
);

// File: tb/sim_mtmr_top.sv
module sim_mtmr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mtmr_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    localparam logic [7:0] A_CNT0 = 8'h00, A_DIV0 = 8'h04, A_CTL0 = 8'h08;
    localparam logic [7:0] A_CNT1 = 8'h0C, A_DIV1 = 8'h10, A_CTL1 = 8'h14;
    localparam logic [7:0] A_STAT = 8'h30, A_MASK = 8'h34;

    function automatic logic [7:0] match_addr(int n);
        return 8'(8'h18 + 4 * n);
    endfunction

    function automatic logic [15:0] stepped(logic [15:0] v, bit up, int k);
        return up ? 16'(v + 16'(k)) : 16'(v - 16'(k));
    endfunction

    function automatic logic [31:0] ctl_word(bit stop, bit up, int mode);
        return {27'd0, stop, up, 3'(mode)};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [15:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check_reg("R2 cnt0", A_CNT0, 0);
        check_reg("R2 div0", A_DIV0, 0);
        check_reg("R2 ctl0", A_CTL0, 32'h10);
        check_reg("R2 ctl1", A_CTL1, 32'h10);
        check_reg("R2 cnt1", A_CNT1, 0);
        for (int n = 0; n < 6; n++) check_reg("R2 match", match_addr(n), 0);
        check_reg("R2 stat", A_STAT, 0);
        check_reg("R2 mask", A_MASK, 0);
        check("R2 irq", {31'd0, irq_o}, 0);

        // R1 register map and widths
        wr(A_DIV0, 32'hABCD_1234);
        check_reg("R1 div0 low bits", A_DIV0, 32'h1234);
        wr(A_DIV1, 32'h0000_0077);
        check_reg("R1 div1", A_DIV1, 32'h77);
        check_reg("R1 div0 untouched", A_DIV0, 32'h1234);
        for (int n = 0; n < 6; n++) begin
            v = 16'($urandom);
            wr(match_addr(n), {16'hFFFF, v});
            check_reg("R1 match readback", match_addr(n), {16'd0, v});
        end
        wr(A_CTL0, 32'hFFFF_FFFF);
        check_reg("R1 ctl0 five bits", A_CTL0, 32'h1F);
        wr(A_CTL0, ctl_word(1, 0, 0));
        wr(A_MASK, 32'hFFFF_FFC0);
        check_reg("R1 mask six bits", A_MASK, 0);

        // R4 R5 zero mode with prescale 2
        wr(A_DIV0, 2);
        wr(A_CNT0, 4);
        wr(A_CTL0, ctl_word(0, 0, 0));
        wait_cyc(2);
        check_reg("R4 no step before D+1", A_CNT0, 4);
        wait_cyc(1);
        check_reg("R4 first step at D+1", A_CNT0, 3);
        wait_cyc(8);
        check_reg("R5 one before zero", A_CNT0, 1);
        check_reg("R5 still running", A_CTL0, ctl_word(0, 0, 0));
        wait_cyc(1);
        check_reg("R5 reached zero", A_CNT0, 0);
        check_reg("R5 halted", A_CTL0, ctl_word(1, 0, 0));
        check_reg("R5 no event", A_STAT, 0);
        wait_cyc(4);
        check_reg("R3 halted holds", A_CNT0, 0);

        // R5 full-range countdown
        wr(A_DIV0, 0);
        wr(A_CNT0, 32'hFFFF);
        wr(A_CTL0, ctl_word(0, 0, 0));
        wait_cyc(65534);
        check_reg("R5 full range near end", A_CNT0, 1);
        wait_cyc(1);
        check_reg("R5 full range zero", A_CNT0, 0);
        check_reg("R5 full range halted", A_CTL0, ctl_word(1, 0, 0));

        // R6 R4 randomized compare runs
        for (int i = 0; i < 20; i++) begin
            int n, k, dv;
            bit up;
            logic [15:0] s, m;
            n  = int'($urandom % 6);
            k  = 1 + int'($urandom % 30);
            dv = int'($urandom % 3);
            up = 1'($urandom);
            s  = 16'($urandom);
            m  = stepped(s, up, k);
            wr(match_addr(n), {16'd0, m});
            wr(A_CNT0, {16'd0, s});
            wr(A_DIV0, dv);
            wr(A_STAT, 32'h3F);
            wr(A_CTL0, ctl_word(0, up, n + 1));
            if (k * (dv + 1) - 1 > 0) begin
                wait_cyc(k * (dv + 1) - 1);
                check_reg("R6 before compare", A_CNT0, {16'd0, stepped(s, up, k - 1)});
                check_reg("R6 no early event", A_STAT, 0);
            end
            wait_cyc(1);
            check_reg("R6 stopped at compare", A_CNT0, {16'd0, m});
            check_reg("R6 halt bit", A_CTL0, ctl_word(1, up, n + 1));
            check_reg("R6 event bit", A_STAT, 32'(1 << n));
            check("R9 masked quiet", {31'd0, irq_o}, 0);
            wait_cyc(3);
            check_reg("R3 holds after compare", A_CNT0, {16'd0, m});
        end

        // R8 R9 interrupt path, event bit 2 pending
        wr(A_STAT, 32'h3F);
        wr(match_addr(2), 32'h0010);
        wr(A_DIV0, 0);
        wr(A_CNT0, 32'h000D);
        wr(A_CTL0, ctl_word(0, 1, 3));
        wait_cyc(4);
        check_reg("R6 bit2 pending", A_STAT, 32'h04);
        check("R9 disabled low", {31'd0, irq_o}, 0);
        wr(A_MASK, 32'h04);
        check("R9 enabled high", {31'd0, irq_o}, 1);
        wait_cyc(5);
        check("R9 level held", {31'd0, irq_o}, 1);
        wr(A_STAT, 32'h3B);
        check_reg("R8 zero bit keeps", A_STAT, 32'h04);
        check("R9 still high", {31'd0, irq_o}, 1);
        wr(A_MASK, 32'h00);
        check("R9 disable drops", {31'd0, irq_o}, 0);
        wr(A_MASK, 32'h04);
        wr(A_STAT, 32'h04);
        check_reg("R8 one clears", A_STAT, 0);
        check("R9 clear drops", {31'd0, irq_o}, 0);

        // R7 channel 1 wraps up
        wr(A_DIV1, 0);
        wr(A_CNT1, 32'hFFFE);
        wr(A_CTL1, ctl_word(0, 1, 7));
        wait_cyc(3);
        check_reg("R7 up wrap", A_CNT1, 32'h0001);
        check_reg("R7 keeps running", A_CTL1, ctl_word(0, 1, 7));

        // R7 channel 0 wraps down in forever mode
        wr(A_CNT0, 32'h0001);
        wr(A_CTL0, ctl_word(0, 0, 7));
        wait_cyc(2);
        check_reg("R7 down wrap", A_CNT0, 32'hFFFF);
        wr(A_CTL0, ctl_word(1, 0, 7));

        // R7 channel 1 compare mode aliases to forever
        wr(match_addr(0), 32'h0005);
        wr(A_CTL1, ctl_word(1, 1, 1));
        wr(A_CNT1, 32'h0003);
        wr(A_CTL1, ctl_word(0, 1, 1));
        wait_cyc(4);
        check_reg("R7 ch1 passes compare", A_CNT1, 32'h0007);
        check_reg("R7 ch1 no halt", A_CTL1, ctl_word(0, 1, 1));
        check_reg("R7 ch1 no event", A_STAT, 0);

        // R3 halting holds count, reload while halted
        wr(A_CTL1, ctl_word(1, 1, 1));
        rd(A_CNT1, d);
        wait_cyc(5);
        check_reg("R3 halt freezes", A_CNT1, d);
        wr(A_CNT1, 32'h0100);
        check_reg("R3 load while halted", A_CNT1, 32'h0100);
        wr(A_CTL1, ctl_word(0, 0, 7));
        wait_cyc(2);
        check_reg("R3 run from loaded", A_CNT1, 32'h00FE);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule